// File: doc/BRIEF.md
# Asynchronous DRAM Strobe Sequencer

This block sits between a simple processor request port and an asynchronous DRAM. A requester raises `req_valid` with a read/write flag and two byte enables, and holds them until `req_ready` pulses. The controller turns that into a timed strobe sequence. The row strobe comes first, then the address multiplexer is switched to the column address. The byte-lane column strobes follow, together with either the output enable or the write enable, and the external data-bus buffer is enabled. A fixed precharge gap closes every cycle.

An internal interval timer raises a refresh request on its own schedule. The refresh is performed as a column-before-row cycle, which needs no address. A pending refresh wins over a waiting access whenever the sequencer is idle. All pins are registered. Cycle counts are set by parameters: the defaults give 75 ns of row phase, 50 ns of column strobe and 25 ns of column-address setup at 40 MHz.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: After synchronous reset every strobe output (`ras_n`, `lcas_n`, `ucas_n`, `oe_n`, `we_n`, `dbuf_en_n`) is high (inactive), `addr_row_sel` is high and `req_ready` is low.
- R2: A request sampled while the sequencer is idle drives `ras_n` low starting the next cycle. `ras_n` stays low for ROW_CYC (3) cycles before any column strobe and remains low through the column phase.
- R3: `addr_row_sel` is high (row address) in the first ROW_CYC-1 row cycles. It goes low in the last row cycle, one cycle before the column strobes, and stays low through the column phase.
- R4: In the column phase, which lasts COL_CYC (2) cycles, `lcas_n` is low when `req_be[0]` was set (low byte lane) and `ucas_n` is low when `req_be[1]` was set (high byte lane). The byte enables are latched when the request is accepted.
- R5: In the column phase a read (`req_write`=0) drives `oe_n` low and a write drives `we_n` low. `oe_n` and `we_n` are never low together.
- R6: `dbuf_en_n` is low exactly during the column phase of a read or write and at no other time.
- R7: `req_ready` is a one-cycle pulse in the last column cycle of each access, which is when read data is valid. There is exactly one pulse per accepted request.
- R8: After every access or refresh, all strobes are high for PRE_CYC (2) precharge cycles and then one idle cycle. `ras_n` therefore stays high for at least 3 cycles between cycles.
- R9: Every REF_INTERVAL clock cycles after reset a refresh becomes pending. It is served as one cycle with both column strobes low and `ras_n` high, followed by ROW_CYC cycles with `ras_n` and both column strobes low. During a refresh `oe_n`, `we_n` and `dbuf_en_n` stay high, `addr_row_sel` stays high and `req_ready` stays low.
- R10: When a refresh is pending and a request is waiting at an idle cycle, the refresh is started first and the request is served afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (40 MHz intended) |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables: bit 0 low lane, bit 1 high lane |
| req_ready | output | 1 | One-cycle completion pulse |
| ras_n | output | 1 | Row address strobe, active low |
| lcas_n | output | 1 | Low-lane column address strobe, active low |
| ucas_n | output | 1 | High-lane column address strobe, active low |
| oe_n | output | 1 | DRAM output enable, active low |
| we_n | output | 1 | DRAM write enable, active low |
| addr_row_sel | output | 1 | Address mux select: 1 row, 0 column |
| dbuf_en_n | output | 1 | External data-bus buffer enable, active low |

## Verification
Reads and writes are each tried with the low lane alone, the high lane alone and both lanes. This separates a swapped lane mapping or swapped OE/WE from a correct one. Requests then arrive back-to-back and with random gaps under a short refresh interval. Back-to-back requests test the precharge gap and the idle cycle. Random gaps make refreshes collide with waiting requests, which exposes wrong arbitration order and a timer that drifts. A behavioural model predicts every pin on every cycle.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ROW,
    PH_COL,
    PH_REFCAS,
    PH_REFRAS,
    PH_PRE
  } phase_e;

  typedef struct packed {
    logic       ras_n;
    logic [1:0] cas_n;   // [0] low lane, [1] high lane
    logic       oe_n;
    logic       we_n;
    logic       row_sel;
    logic       buf_en_n;
    logic       ready;
  } pins_t;

  localparam pins_t PINS_IDLE = '{ras_n: 1'b1, cas_n: 2'b11, oe_n: 1'b1, we_n: 1'b1,
                                  row_sel: 1'b1, buf_en_n: 1'b1, ready: 1'b0};

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int REF_INTERVAL = 624
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pending
);
  localparam int CW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_INTERVAL - 1);

  logic [CW-1:0] tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick    <= '0;
      pending <= 1'b0;
    end else begin
      if (tick == LAST) begin
        tick    <= '0;
        pending <= 1'b1;
      end else begin
        tick <= tick + 1'b1;
        if (ack) pending <= 1'b0;
      end
    end
  end

  // R9: a pending refresh stays pending until the sequencer takes it
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (rst)
    pending && !ack |=> pending);

endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_CYC = 3,
  parameter int COL_CYC = 2,
  parameter int PRE_CYC = 2,
  parameter int LANES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_be,
  input  logic             ref_pending,
  output logic             ref_ack,
  output phase_e           nxt_phase,
  output logic             nxt_last,
  output logic             nxt_write,
  output logic [LANES-1:0] nxt_be
);
  localparam int MAXC = (ROW_CYC > COL_CYC) ? ((ROW_CYC > PRE_CYC) ? ROW_CYC : PRE_CYC)
                                            : ((COL_CYC > PRE_CYC) ? COL_CYC : PRE_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ROW_LD = CW'(ROW_CYC - 1);
  localparam logic [CW-1:0] COL_LD = CW'(COL_CYC - 1);
  localparam logic [CW-1:0] PRE_LD = CW'(PRE_CYC - 1);

  phase_e           phase;
  logic [CW-1:0]    cnt, nxt_cnt;
  logic             op_write;
  logic [LANES-1:0] op_be;

  always_comb begin
    nxt_phase = phase;
    nxt_cnt   = cnt;
    nxt_write = op_write;
    nxt_be    = op_be;
    ref_ack   = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (ref_pending) begin
          nxt_phase = PH_REFCAS;
          nxt_cnt   = '0;
          ref_ack   = 1'b1;
        end else if (req_valid) begin
          nxt_phase = PH_ROW;
          nxt_cnt   = ROW_LD;
          nxt_write = req_write;
          nxt_be    = req_be;
        end
      end
      PH_ROW: begin
        if (cnt == '0) begin
          nxt_phase = PH_COL;
          nxt_cnt   = COL_LD;
        end else nxt_cnt = cnt - 1'b1;
      end
      PH_COL: begin
        if (cnt == '0) begin
          nxt_phase = PH_PRE;
          nxt_cnt   = PRE_LD;
        end else nxt_cnt = cnt - 1'b1;
      end
      PH_REFCAS: begin
        nxt_phase = PH_REFRAS;
        nxt_cnt   = ROW_LD;
      end
      PH_REFRAS: begin
        if (cnt == '0) begin
          nxt_phase = PH_PRE;
          nxt_cnt   = PRE_LD;
        end else nxt_cnt = cnt - 1'b1;
      end
      PH_PRE: begin
        if (cnt == '0) nxt_phase = PH_IDLE;
        else nxt_cnt = cnt - 1'b1;
      end
      default: begin
        nxt_phase = PH_IDLE;
        nxt_cnt   = '0;
      end
    endcase
  end

  assign nxt_last = (nxt_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      op_write <= 1'b0;
      op_be    <= '0;
    end else begin
      phase    <= nxt_phase;
      cnt      <= nxt_cnt;
      op_write <= nxt_write;
      op_be    <= nxt_be;
    end
  end

  // R10: a refresh is only taken from idle, never in the middle of an access
  p_ack_from_idle_r10: assert property (@(posedge clk) disable iff (rst)
    ref_ack |=> phase == PH_REFCAS);

endmodule

// File: rtl/dram_pin_drive.sv
module dram_pin_drive
  import dram_ctrl_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  phase_e           nxt_phase,
  input  logic             nxt_last,
  input  logic             nxt_write,
  input  logic [LANES-1:0] nxt_be,
  output pins_t            pins
);
  pins_t d;
  logic  col, ref_any;

  assign col     = (nxt_phase == PH_COL);
  assign ref_any = (nxt_phase == PH_REFCAS) || (nxt_phase == PH_REFRAS);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign d.cas_n[g] = !((col && nxt_be[g]) || ref_any);
  end

  assign d.ras_n    = !((nxt_phase == PH_ROW) || col || (nxt_phase == PH_REFRAS));
  assign d.row_sel  = !(((nxt_phase == PH_ROW) && nxt_last) || col);
  assign d.oe_n     = !(col && !nxt_write);
  assign d.we_n     = !(col && nxt_write);
  assign d.buf_en_n = !col;
  assign d.ready    = col && nxt_last;

  always_ff @(posedge clk) begin
    if (rst) pins <= PINS_IDLE;
    else     pins <= d;
  end

endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_CYC      = 3,
  parameter int COL_CYC      = 2,
  parameter int PRE_CYC      = 2,
  parameter int REF_INTERVAL = 624
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [1:0] req_be,
  output logic       req_ready,
  output logic       ras_n,
  output logic       lcas_n,
  output logic       ucas_n,
  output logic       oe_n,
  output logic       we_n,
  output logic       addr_row_sel,
  output logic       dbuf_en_n
);
  localparam int LANES = 2;

  logic             ref_pending, ref_ack;
  phase_e           nxt_phase;
  logic             nxt_last, nxt_write;
  logic [LANES-1:0] nxt_be;
  pins_t            pins;

  dram_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst(rst), .ack(ref_ack), .pending(ref_pending)
  );

  dram_cycle_seq #(
    .ROW_CYC(ROW_CYC), .COL_CYC(COL_CYC), .PRE_CYC(PRE_CYC), .LANES(LANES)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_be(req_be), .ref_pending(ref_pending), .ref_ack(ref_ack),
    .nxt_phase(nxt_phase), .nxt_last(nxt_last), .nxt_write(nxt_write), .nxt_be(nxt_be)
  );

  dram_pin_drive #(.LANES(LANES)) u_pins (
    .clk(clk), .rst(rst), .nxt_phase(nxt_phase), .nxt_last(nxt_last),
    .nxt_write(nxt_write), .nxt_be(nxt_be), .pins(pins)
  );

  assign ras_n        = pins.ras_n;
  assign lcas_n       = pins.cas_n[0];
  assign ucas_n       = pins.cas_n[1];
  assign oe_n         = pins.oe_n;
  assign we_n         = pins.we_n;
  assign addr_row_sel = pins.row_sel;
  assign dbuf_en_n    = pins.buf_en_n;
  assign req_ready    = pins.ready;

  // R5: output enable and write enable never overlap
  p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));

  // R7: ready is a single-cycle pulse
  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  // R3: column address is selected the cycle before the transfer starts
  p_sel_before_cas_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(dbuf_en_n) |-> !$past(addr_row_sel));

  // R6: buffer enabled only while row and a column strobe are active
  p_buf_in_col_r6: assert property (@(posedge clk) disable iff (rst)
    !dbuf_en_n |-> (!ras_n && (!lcas_n || !ucas_n)));

  // R8: row strobe precharge of at least two cycles
  p_precharge_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |=> ras_n ##1 ras_n);

  // R9: column-before-row start leaves data path and address select inactive
  p_cbr_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!lcas_n && ras_n) |-> (oe_n && we_n && dbuf_en_n && addr_row_sel && !ucas_n));

endmodule

// File: tb/test_dram_strobe_ctrl.sv
module test_dram_strobe_ctrl;
  localparam int REF_N = 40;
  localparam logic [7:0] IDLE_V = 8'b1111_1110; // ras,lcas,ucas,oe,we,sel,buf,rdy

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_be = 2'b00;
  logic req_ready, ras_n, lcas_n, ucas_n, oe_n, we_n, addr_row_sel, dbuf_en_n;

  always #5 clk = ~clk;

  dram_strobe_ctrl #(.REF_INTERVAL(REF_N)) i_dram_strobe_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_be(req_be),
    .req_ready(req_ready), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n), .oe_n(oe_n),
    .we_n(we_n), .addr_row_sel(addr_row_sel), .dbuf_en_n(dbuf_en_n)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference: a queue of expected pin vectors per cycle
  logic [7:0] q[$];
  logic [7:0] m_exp = IDLE_V;
  int m_tick = 0, m_acc = 0, m_refs = 0, m_coll = 0;
  bit m_pend = 0;

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_tick = 0; m_pend = 0; m_exp = IDLE_V;
    end else begin
      if (q.size() == 0) begin
        if (m_pend) begin
          m_pend = 0; m_refs++;
          if (req_valid) m_coll++;
          q.push_back(8'b1001_1110);
          for (int i = 0; i < 3; i++) q.push_back(8'b0001_1110);
          for (int i = 0; i < 3; i++) q.push_back(IDLE_V);
        end else if (req_valid) begin
          m_acc++;
          for (int i = 0; i < 3; i++) q.push_back({1'b0, 4'b1111, (i == 2) ? 1'b0 : 1'b1, 2'b10});
          for (int i = 0; i < 2; i++)
            q.push_back({1'b0, ~req_be[0], ~req_be[1], req_write, ~req_write, 1'b0, 1'b0, (i == 1)});
          for (int i = 0; i < 3; i++) q.push_back(IDLE_V);
        end
      end
      m_exp = (q.size() != 0) ? q.pop_front() : IDLE_V;
      m_tick++;
      if (m_tick == REF_N) begin m_tick = 0; m_pend = 1; end
    end
  end

  // per-cycle comparison, away from the active edge
  bit run = 0;
  int o_rdy = 0, o_refs = 0, hi_run = 0, min_gap = 1000;
  bit prev_cbr = 0, seen_low = 0;
  always @(negedge clk) begin
    if (run && !rst) begin
      chk("R2 ras_n", ras_n, m_exp[7]);
      chk("R4 lcas_n", lcas_n, m_exp[6]);
      chk("R4 ucas_n", ucas_n, m_exp[5]);
      chk("R5 oe_n", oe_n, m_exp[4]);
      chk("R5 we_n", we_n, m_exp[3]);
      chk("R3 addr_row_sel", addr_row_sel, m_exp[2]);
      chk("R6 dbuf_en_n", dbuf_en_n, m_exp[1]);
      chk("R7 req_ready", req_ready, m_exp[0]);
      if (req_ready) o_rdy++;
      if (!lcas_n && ras_n && !prev_cbr) o_refs++;
      prev_cbr = !lcas_n && ras_n;
      if (ras_n) hi_run++;
      else begin
        if (seen_low && hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
        seen_low = 1; hi_run = 0;
      end
    end
  end

  bit done = 0;
  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic access(bit wr, logic [1:0] be, int gap);
    int k = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_be = be;
    do begin @(negedge clk); k++; end while (!req_ready && k < 60);
    if (!req_ready) chk("R7 ready timeout", 0, 1);
    req_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  int unsigned seed = 32'h1234_5678;
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run = 1;
    // R1: reset state visible right after release
    chk("R1 ras_n", ras_n, 1); chk("R1 lcas_n", lcas_n, 1); chk("R1 ucas_n", ucas_n, 1);
    chk("R1 oe_n", oe_n, 1); chk("R1 we_n", we_n, 1); chk("R1 dbuf_en_n", dbuf_en_n, 1);
    chk("R1 addr_row_sel", addr_row_sel, 1); chk("R1 req_ready", req_ready, 0);
    // directed lane/direction combinations
    for (int w = 0; w < 2; w++)
      for (int b = 1; b < 4; b++) access(w[0], b[1:0], 2);
    // back-to-back
    for (int i = 0; i < 8; i++) access(i[0], 2'b11, 0);
    // random gaps to collide with refresh
    for (int i = 0; i < 300; i++) begin
      seed = seed * 1103515245 + 12345;
      access(seed[16], (seed[18:17] == 2'b00) ? 2'b01 : seed[18:17], int'(seed[21:19]) % 5);
    end
    repeat (60) @(negedge clk);
    chk("R7 ready count", o_rdy, m_acc);
    chk("R9 refresh count", o_refs, m_refs);
    chk("R9 refresh happened", (o_refs > 10) ? 1 : 0, 1);
    chk("R8 min ras high gap", (min_gap >= 3) ? 1 : 0, 1);
    chk("R10 refresh-before-request seen", (m_coll > 0) ? 1 : 0, 1);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule